// File: doc/BRIEF.md
# Multi-Channel Timer Compare Unit with Pulse Output

This block watches a free-running time counter supplied from outside and gives each of its channels a programmable compare point. When the counter reaches the armed compare value of an enabled channel, that channel latches an event flag, can raise a shared interrupt or a per-channel DMA request, and acts on its output pin as its mode selects: it flips the pin, drives a pulse of fixed length, or leaves the pin alone. A typical use is a once-per-second timing pulse. Software arms the first compare point, queues the next one, and after every event writes the one after that.

Each channel holds an active compare value and a one-deep queue behind it. At a match the queued value becomes the active one. If nothing is queued, the channel disarms. A small register interface with a combinational read path exposes a shared status word and, per channel, a control/status word and a compare word.

Top module: `tcmp_unit`

## Requirements
- R1: After reset every register reads 0, and all pins, DMA requests and the interrupt are low.
- R2: Address map, in bytes. The status word is at 0x04. Channel n has its control word at 0x08+8n and its compare word at 0x0C+8n. Control bits: 7 = event flag, 6 = interrupt enable, 5:2 = mode, 0 = DMA enable. Bit 1 and bits 31:8 read 0. Writes to the status word are ignored.
- R3: When a channel's mode is non-zero and its active compare is armed and equal to the counter, its event flag is set at the next clock edge. The flag appears in status bit n and in control bit 7.
- R4: While a channel's mode is 0, no match is detected and the flag does not rise.
- R5: A control write with bit 7 = 1 clears the flag. A write with bit 7 = 0 leaves the flag unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R6: A compare write goes to the active value when the mode is 0 or the active value is unarmed. Otherwise it goes to the queue. At a match the queued value becomes active, or the channel disarms if the queue is empty. The compare word reads back the active value. A compare write in the same cycle as a match that empties the channel arms the written value.
- R7: Mode 0x5 inverts the pin at each match.
- R8: Mode 0xF drives the pin high for exactly PULSE_LEN clock cycles, starting at the edge that registers the match.
- R9: Any other non-zero mode sets the flag at a match and leaves the pin unchanged.
- R10: Writing a mode of 0 turns the channel off. The pin goes low at that edge and the queued compare value is discarded.
- R11: The interrupt is high when any channel has both its flag and its interrupt enable set. dma_req[n] is the flag of channel n ANDed with its DMA enable.
- R12: Channels run independently, and the status word shows all of their flags at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_i | input | CW | Current value of the shared time counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address of register access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| chan_out | output | NCH | Per-channel output pins |
| dma_req | output | NCH | Per-channel DMA requests |
| irq | output | 1 | Shared interrupt |

## Verification
Two pairs of actions can land on the same edge. In the first, a compare match coincides with a software write that clears the flag. The bench holds the counter on the compare point during that write, and the flag must still read as set. In the second, a compare write coincides with a match that leaves the channel without a queued value. The bench writes the new compare value while the counter sits on the old one. The readback must show the new value armed, and a later match at that value must set the flag again. Every channel is also swept across the toggle, pulse and flag-only modes, and the expected pin levels are computed cycle by cycle from the pulse length.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  // byte offsets of the register window
  localparam int STAT_OFS  = 4;
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 8;
  localparam int CMP_OFS   = 4;

  // control word bit positions (decoded by software)
  localparam int FLAG_B  = 7;
  localparam int IE_B    = 6;
  localparam int MODE_LO = 2;
  localparam int MODE_W  = 4;
  localparam int DRE_B   = 0;

  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_OFF    = 4'h0;
  localparam mode_t MODE_TOGGLE = 4'h5;
  localparam mode_t MODE_PULSE  = 4'hF;
endpackage

// File: rtl/tcmp_rst_sync.sv
module tcmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
  import tcmp_pkg::*;
#(
  parameter int CW        = 31,
  parameter int DW        = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          ctrl_we,
  input  logic          cmp_we,
  input  logic [DW-1:0] wdata,
  output logic [7:0]    ctrl_rd,
  output logic [CW-1:0] cmp_rd,
  output logic          flag_o,
  output logic          mode_nz_o,
  output logic          clr_o,
  output logic          pin_o,
  output logic          dma_o,
  output logic          irq_o
);
  localparam int PCW = $clog2(PULSE_LEN + 1);

  logic          flag_q, flag_d;
  logic          ie_q, ie_d;
  logic          dre_q, dre_d;
  mode_t         mode_q, mode_d;
  logic [CW-1:0] act_q, act_d;
  logic          act_vld_q, act_vld_d;
  logic [CW-1:0] buf_q, buf_d;
  logic          buf_vld_q, buf_vld_d;
  logic          pin_q, pin_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;

  logic hit;
  logic clr;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  assign hit = (mode_q != MODE_OFF) && act_vld_q && (count_i == act_q);
  assign clr = ctrl_we && wdata[FLAG_B];

  // control fields and event flag
  always_comb begin
    flag_d = hit | (flag_q & ~clr);
    ie_d   = ctrl_we ? wdata[IE_B]  : ie_q;
    dre_d  = ctrl_we ? wdata[DRE_B] : dre_q;
    mode_d = ctrl_we ? wdata[MODE_LO +: MODE_W] : mode_q;
  end

  // active compare and one-deep queue
  always_comb begin
    act_d     = act_q;
    act_vld_d = act_vld_q;
    buf_d     = buf_q;
    buf_vld_d = buf_vld_q;
    if (hit) begin
      if (buf_vld_q) begin
        act_d     = buf_q;
        buf_vld_d = 1'b0;
      end else begin
        act_vld_d = 1'b0;
      end
    end
    if (cmp_we) begin
      if ((mode_q == MODE_OFF) || !act_vld_d) begin
        act_d     = wdata[CW-1:0];
        act_vld_d = 1'b1;
        buf_vld_d = 1'b0;
      end else begin
        buf_d     = wdata[CW-1:0];
        buf_vld_d = 1'b1;
      end
    end
    if (mode_d == MODE_OFF) buf_vld_d = 1'b0;
  end

  // pin action
  always_comb begin
    pin_d  = pin_q;
    pcnt_d = pcnt_q;
    if (mode_d == MODE_OFF) begin
      pin_d  = 1'b0;
      pcnt_d = '0;
    end else if (hit) begin
      if (mode_q == MODE_TOGGLE) begin
        pin_d = ~pin_q;
      end else if (mode_q == MODE_PULSE) begin
        pin_d  = 1'b1;
        pcnt_d = PCW'(PULSE_LEN - 1);
      end
    end else if ((mode_q == MODE_PULSE) && pin_q) begin
      if (pcnt_q == '0) pin_d  = 1'b0;
      else              pcnt_d = pcnt_q - PCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      ie_q      <= 1'b0;
      dre_q     <= 1'b0;
      mode_q    <= MODE_OFF;
      act_q     <= '0;
      act_vld_q <= 1'b0;
      buf_q     <= '0;
      buf_vld_q <= 1'b0;
      pin_q     <= 1'b0;
      pcnt_q    <= '0;
    end else begin
      flag_q    <= flag_d;
      ie_q      <= ie_d;
      dre_q     <= dre_d;
      mode_q    <= mode_d;
      act_vld_q <= act_vld_d;
      buf_vld_q <= buf_vld_d;
      pin_q     <= pin_d;
      pcnt_q    <= pcnt_d;
      if (act_d != act_q) act_q <= act_d;
      if (cmp_we)         buf_q <= buf_d;
    end
  end

  assign ctrl_rd   = {flag_q, ie_q, mode_q, 1'b0, dre_q};
  assign cmp_rd    = act_q;
  assign flag_o    = flag_q;
  assign mode_nz_o = (mode_q != MODE_OFF);
  assign clr_o     = clr;
  assign pin_o     = pin_q;
  assign dma_o     = flag_q & dre_q;
  assign irq_o     = flag_q & ie_q;
endmodule

// File: rtl/tcmp_regmux.sv
module tcmp_regmux
  import tcmp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 6,
  parameter int CW  = 31,
  parameter int DW  = 32
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [NCH-1:0]    flags,
  input  logic [NCH*8-1:0]  ctrl_flat,
  input  logic [NCH*CW-1:0] cmp_flat,
  output logic [NCH-1:0]    ctrl_we,
  output logic [NCH-1:0]    cmp_we,
  output logic [DW-1:0]     rdata
);
  logic [NCH-1:0] ctrl_sel;
  logic [NCH-1:0] cmp_sel;

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    localparam int CTRL_A = CH_BASE + n * CH_STRIDE;
    localparam int CMP_A  = CTRL_A + CMP_OFS;
    assign ctrl_sel[n] = (addr == AW'(CTRL_A));
    assign cmp_sel[n]  = (addr == AW'(CMP_A));
    assign ctrl_we[n]  = wr && ctrl_sel[n];
    assign cmp_we[n]   = wr && cmp_sel[n];
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(STAT_OFS)) rdata[NCH-1:0] = flags;
    for (int n = 0; n < NCH; n++) begin
      if (ctrl_sel[n]) rdata[7:0]    = ctrl_flat[n*8 +: 8];
      if (cmp_sel[n])  rdata[CW-1:0] = cmp_flat[n*CW +: CW];
    end
  end
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit #(
  parameter int NCH       = 4,
  parameter int CW        = 31,
  parameter int AW        = 6,
  parameter int DW        = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  count_i,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] chan_out,
  output logic [NCH-1:0] dma_req,
  output logic           irq
);
  logic rst_sync_n;
  logic [NCH-1:0]    ctrl_we, cmp_we;
  logic [NCH-1:0]    flag_v, mode_nz_v, clr_v, irq_v;
  logic [NCH*8-1:0]  ctrl_flat;
  logic [NCH*CW-1:0] cmp_flat;

  tcmp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tcmp_regmux #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_regs (
    .addr      (bus_addr),
    .wr        (bus_wr),
    .flags     (flag_v),
    .ctrl_flat (ctrl_flat),
    .cmp_flat  (cmp_flat),
    .ctrl_we   (ctrl_we),
    .cmp_we    (cmp_we),
    .rdata     (bus_rdata)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    tcmp_channel #(.CW(CW), .DW(DW), .PULSE_LEN(PULSE_LEN)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .count_i   (count_i),
      .ctrl_we   (ctrl_we[n]),
      .cmp_we    (cmp_we[n]),
      .wdata     (bus_wdata),
      .ctrl_rd   (ctrl_flat[n*8 +: 8]),
      .cmp_rd    (cmp_flat[n*CW +: CW]),
      .flag_o    (flag_v[n]),
      .mode_nz_o (mode_nz_v[n]),
      .clr_o     (clr_v[n]),
      .pin_o     (chan_out[n]),
      .dma_o     (dma_req[n]),
      .irq_o     (irq_v[n])
    );
  end

  assign irq = |irq_v;
endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] flag_v,
  input logic [NCH-1:0] mode_nz_v,
  input logic [NCH-1:0] clr_v,
  input logic [NCH-1:0] chan_out,
  input logic [NCH-1:0] dma_req,
  input logic           irq
);
  for (genvar n = 0; n < NCH; n++) begin : g_a
    a_r4_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_nz_v[n] && !flag_v[n]) |=> !flag_v[n]);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v[n] && !clr_v[n]) |=> flag_v[n]);
    a_r10_off_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_nz_v[n] |-> !chan_out[n]);
    a_r11_dma_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[n] |-> flag_v[n]);
  end

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_v != '0));
endmodule

bind tcmp_unit tcmp_unit_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_v    (flag_v),
  .mode_nz_v (mode_nz_v),
  .clr_v     (clr_v),
  .chan_out  (chan_out),
  .dma_req   (dma_req),
  .irq       (irq)
);

// File: tb/tb_tcmp_unit.sv
module tb_tcmp_unit;
  localparam int NCH = 4;
  localparam int CW  = 31;
  localparam int AW  = 6;
  localparam int DW  = 32;
  localparam int PL  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic [CW-1:0]  count_i;
  logic           bus_wr;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic [NCH-1:0] chan_out;
  logic [NCH-1:0] dma_req;
  logic           irq;

  int errors = 0;
  int checks = 0;

  tcmp_unit #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_out(chan_out), .dma_req(dma_req), .irq(irq)
  );

  function automatic int ca(input int n); return 8 + 8 * n; endfunction
  function automatic int cm(input int n); return 12 + 8 * n; endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = AW'(a);
    #1 v = bus_rdata;
  endtask

  task automatic setcnt(input int c);
    count_i = CW'(c);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    rst_n = 1'b0; count_i = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4, v); chk("R1 status", v, 0);
    for (int n = 0; n < NCH; n++) begin
      rd(ca(n), v); chk("R1 ctrl", v, 0);
      rd(cm(n), v); chk("R1 cmp", v, 0);
    end
    chk("R1 pins", chan_out, 0);
    chk("R1 dma", dma_req, 0);
    chk("R1 irq", irq, 0);

    // R2 field readback, reserved bits, status write ignored
    for (int n = 0; n < NCH; n++) begin
      wr(ca(n), 32'hFFFF_FF7F);
      rd(ca(n), v); chk("R2 ctrl fields", v, 32'h7D);
      wr(ca(n), 32'h0);
      rd(ca(n), v); chk("R2 ctrl cleared", v, 0);
    end
    wr(4, 32'hF);
    rd(4, v); chk("R2 status write ignored", v, 0);

    // sweep: each channel through toggle, pulse and flag-only modes
    for (int n = 0; n < NCH; n++) begin
      for (int mi = 0; mi < 3; mi++) begin
        automatic int md = (mi == 0) ? 5 : (mi == 1) ? 15 : 9;
        automatic logic [31:0] cw = 32'h40 | (md << 2);
        setcnt(100);
        wr(ca(n), 0);
        wr(cm(n), 110);
        wr(ca(n), cw);
        wr(cm(n), 120);
        rd(cm(n), v); chk("R6 active before match", v, 110);
        chk("R9 pin idle", chan_out[n], 0);
        setcnt(110);
        rd(4, v); chk("R3 status bit", v, 1 << n);
        rd(ca(n), v); chk("R3 ctrl flag", v, 32'h80 | cw);
        chk("R11 irq", irq, 1);
        rd(cm(n), v); chk("R6 queue promoted", v, 120);
        if (md == 5) chk("R7 toggle high", chan_out[n], 1);
        else if (md == 15) chk("R8 pulse start", chan_out[n], 1);
        else chk("R9 pin unchanged", chan_out[n], 0);
        for (int k = 1; k <= PL; k++) begin
          setcnt(110 + k);
          if (md == 15) chk("R8 pulse width", chan_out[n], (k < PL) ? 1 : 0);
          else if (md == 5) chk("R7 toggle holds", chan_out[n], 1);
        end
        wr(ca(n), 32'h80 | cw);
        rd(ca(n), v); chk("R5 flag cleared", v, cw);
        chk("R11 irq low", irq, 0);
        setcnt(120);
        rd(ca(n), v); chk("R3 second event", v[7], 1);
        if (md == 5) chk("R7 toggle low", chan_out[n], 0);
        if (md == 15) chk("R8 pulse restart", chan_out[n], 1);
        wr(ca(n), 32'h80 | cw);
        setcnt(120);
        rd(ca(n), v); chk("R6 disarmed after empty", v[7], 0);
        wr(ca(n), 0);
        chk("R10 pin off", chan_out[n], 0);
      end
    end

    // R4: mode 0 never matches
    wr(ca(1), 0);
    wr(cm(1), 200);
    setcnt(200);
    setcnt(200);
    rd(ca(1), v); chk("R4 no flag when off", v, 0);
    rd(4, v); chk("R4 status", v, 0);

    // R5 / R11: clear coinciding with a match
    setcnt(299);
    wr(ca(0), 0);
    wr(cm(0), 300);
    wr(ca(0), (9 << 2) | 1);
    wr(cm(0), 310);
    setcnt(300);
    chk("R11 dma", dma_req, 4'b0001);
    chk("R11 irq masked", irq, 0);
    setcnt(305);
    count_i = CW'(310);
    wr(ca(0), 32'h80 | (9 << 2) | 1);
    rd(ca(0), v); chk("R5 match beats clear", v[7], 1);
    setcnt(311);
    wr(ca(0), 32'h80 | (9 << 2) | 1);
    rd(ca(0), v); chk("R5 clear", v[7], 0);
    chk("R11 dma low", dma_req, 0);

    // R6: compare write coinciding with an emptying match
    wr(ca(0), 0);
    wr(cm(0), 400);
    wr(ca(0), 9 << 2);
    count_i = CW'(400);
    wr(cm(0), 410);
    rd(ca(0), v); chk("R6 flag at collision", v[7], 1);
    rd(cm(0), v); chk("R6 write armed", v, 410);
    setcnt(405);
    wr(ca(0), 32'h80 | (9 << 2));
    setcnt(410);
    rd(ca(0), v); chk("R6 rearmed match", v[7], 1);
    setcnt(411);
    wr(ca(0), 32'h80 | (9 << 2));

    // R10: turning off discards the queue
    wr(ca(0), 0);
    wr(cm(0), 500);
    wr(ca(0), 9 << 2);
    wr(cm(0), 510);
    wr(ca(0), 0);
    wr(ca(0), 9 << 2);
    setcnt(500);
    rd(cm(0), v); chk("R10 queue dropped", v, 500);
    setcnt(501);
    wr(ca(0), 32'h80 | (9 << 2));
    setcnt(510);
    rd(ca(0), v); chk("R10 no late match", v[7], 0);

    // R12: two channels at once
    setcnt(599);
    wr(ca(0), 0); wr(ca(2), 0);
    wr(cm(0), 600); wr(cm(2), 600);
    wr(ca(0), 32'h40 | (9 << 2)); wr(ca(2), 32'h40 | (9 << 2));
    setcnt(600);
    rd(4, v); chk("R12 status gathers", v, 5);
    chk("R12 irq", irq, 1);

    summary();
    $finish;
  end
endmodule